// File: doc/BRIEF.md
# Power-Up Strap Capture and Test-Mode Controller

This block sits in the control section of a clock generator. When the power-good input first rises, it records the configuration straps. The straps are a three-bit CPU frequency code, the pin-function select for the SRC5 pair versus the stop inputs, and the pin-function select for the ITP versus SRC8 pair. From the recorded code it derives the CPU output frequency. It then holds all of these values steady, so that the rest of the chip and the readback registers see fixed values.

The block also owns test mode. Test mode can start in two ways:
- At power-up, when the three-level frequency/test-select pin is above the upper threshold. An upstream comparator reports this as a digital flag.
- Later, when software sets a test-entry configuration bit.

In test mode the outputs are either held in high impedance or driven with the reference clock divided by N. The choice follows different rules in the two entry paths. Once test mode is active, only a power cycle clears it; in this block a power cycle is the synchronous reset.

Top module: `strap_test_ctrl`

## Requirements
- R1: `pwr_good_in` passes through a SYNC_STAGES-flop synchronizer. The straps are taken on the first clock edge that sees the synchronized rising edge. With SYNC_STAGES=2, `straps_valid` and the latched values appear after the third rising clock edge that follows `pwr_good_in` going high. Until then every output is 0.
- R2: Once taken, the latched straps do not change. Later falls and rises of `pwr_good_in` do not capture them again. Only `rst` re-arms the capture.
- R3: `fs_code_q` is {FSLC, FSLB, FSLA}, with bit 2 the most significant. `cpu_freq_10khz` gives the CPU frequency in units of 10 kHz: 000→26666, 001→13333, 010→20000, 011→16666, 100→33333, 101→10000, 110→40000. Code 111 is reserved: it gives 0 with `fs_reserved`=1.
- R4: `src5_pair_sel` holds the latched SRC5 strap. 1 selects the SRC5 output pair; 0 selects the CPU/PCI stop inputs.
- R5: `itp_pair_sel` holds the latched ITP strap. 1 makes the shared pair ITP; 0 makes it SRC8.
- R6: If `tsel_high_in` is 1 at capture, `test_active` and `test_by_strap` go to 1 in the same cycle as `straps_valid`. `fs_code_q[2]` then reads 1, because the pin level is above the FSLC threshold. If `tsel_high_in` is 0 at capture, bit 2 is taken from `fs_pin[2]`.
- R7: In test mode entered by the strap, the output shows the divided reference when `tmode_pin_in` OR `cfg_refdiv_sel` is 1. Otherwise `out_hiz_req`=1. This follows the inputs combinationally.
- R8: If the straps were taken with `tsel_high_in`=0, then `cfg_test_enter`=1 enters test mode from the next clock edge, with `test_by_strap`=0. In this mode `cfg_refdiv_sel` alone selects divided reference (1) or high impedance (0), and `tmode_pin_in` is ignored.
- R9: Test mode stays active until `rst`, even after `cfg_test_enter` returns to 0. `cfg_test_enter` is ignored before the straps are valid.
- R10: While the divided reference is selected, `refdiv_out` repeats every DIV_N clocks and is high for DIV_N/2 of them (DIV_N even). In all other cases `refdiv_out`=0. Outside test mode, `out_hiz_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the source of the divided test output |
| rst | input | 1 | Synchronous active-high reset; stands for a power cycle |
| pwr_good_in | input | 1 | Asynchronous power-good level |
| fs_pin | input | 3 | Frequency-select strap levels {FSLC, FSLB, FSLA} |
| tsel_high_in | input | 1 | Test-select pin above the upper threshold |
| src5_strap_in | input | 1 | SRC5/stop-function strap |
| itp_strap_in | input | 1 | ITP/SRC8 strap |
| tmode_pin_in | input | 1 | Real-time test output select pin |
| cfg_test_enter | input | 1 | Configuration bit: enter test mode |
| cfg_refdiv_sel | input | 1 | Configuration bit: divided reference (1) or high impedance (0) |
| straps_valid | output | 1 | Straps have been captured |
| fs_code_q | output | 3 | Latched frequency code |
| cpu_freq_10khz | output | 17 | Decoded CPU frequency in 10 kHz units |
| fs_reserved | output | 1 | Latched code is the reserved value |
| src5_pair_sel | output | 1 | 1 = SRC5 pair, 0 = stop inputs |
| itp_pair_sel | output | 1 | 1 = ITP pair, 0 = SRC8 pair |
| test_active | output | 1 | Test mode is on |
| test_by_strap | output | 1 | Test mode came from the power-up strap |
| out_hiz_req | output | 1 | Request to tristate the clock outputs |
| refdiv_out | output | 1 | Reference divided by DIV_N |

## Verification
The hardest condition to reach from the ports is a second power-good rise that must not capture the straps again. The stimulus changes every strap after capture, drops power-good for several cycles, raises it again and checks that the readback is unchanged. The other difficult area is the different roles of the test pin in the two entry paths. Each path needs its own power cycle with a different test-select level. The bench drives the pin high in the software path, where it must have no effect, and in the strap path, where it must switch the output.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int FREQ_W = 17;

    typedef struct packed {
        logic [2:0] fs;
        logic       src5;
        logic       itp;
        logic       tsel;
    } strap_t;

    typedef enum logic [1:0] {
        TOUT_NORMAL = 2'd0,
        TOUT_HIZ    = 2'd1,
        TOUT_REFDIV = 2'd2
    } tout_e;

    function automatic logic [FREQ_W-1:0] fs_to_freq(input logic [2:0] code);
        logic [FREQ_W-1:0] f;
        case (code)
            3'b000:  f = FREQ_W'(26666);
            3'b001:  f = FREQ_W'(13333);
            3'b010:  f = FREQ_W'(20000);
            3'b011:  f = FREQ_W'(16666);
            3'b100:  f = FREQ_W'(33333);
            3'b101:  f = FREQ_W'(10000);
            3'b110:  f = FREQ_W'(40000);
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/pg_rise_sync.sv
module pg_rise_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] shreg;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) shreg <= '0;
                else     shreg <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) shreg <= '0;
                else     shreg <= {shreg[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= shreg[STAGES-1];
    end

    assign rise_pulse = shreg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   capture,
    input  strap_t pins,
    output logic   valid,
    output strap_t held
);
    strap_t next_val;

    always_comb begin
        next_val       = pins;
        // an above-test-threshold level also reads as a high FSLC bit
        next_val.fs[2] = pins.fs[2] | pins.tsel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            held  <= '0;
        end else if (capture && !valid) begin
            valid <= 1'b1;
            held  <= next_val;
        end
    end
endmodule

// File: rtl/test_mode_ctrl.sv
module test_mode_ctrl
    import strap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  straps_ok,
    input  logic  strap_test,
    input  logic  sw_enter,
    input  logic  tmode_pin,
    input  logic  refdiv_bit,
    output logic  active,
    output tout_e choice
);
    logic sw_mode_q;
    logic want_div;

    always_ff @(posedge clk) begin
        if (rst)
            sw_mode_q <= 1'b0;
        else if (straps_ok && !strap_test && sw_enter)
            sw_mode_q <= 1'b1;
    end

    assign active   = strap_test | sw_mode_q;
    assign want_div = strap_test ? (tmode_pin | refdiv_bit) : refdiv_bit;

    always_comb begin
        if (!active)       choice = TOUT_NORMAL;
        else if (want_div) choice = TOUT_REFDIV;
        else               choice = TOUT_HIZ;
    end
endmodule

// File: rtl/ref_div.sv
module ref_div #(
    parameter int DIV_N = 2
) (
    input  logic clk,
    input  logic rst,
    output logic level
);
    localparam int CW = (DIV_N > 1) ? $clog2(DIV_N) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV_N / 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign level = (cnt < HALF);
endmodule

// File: rtl/strap_test_ctrl.sv
module strap_test_ctrl
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_N       = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwr_good_in,
    input  logic [2:0]          fs_pin,
    input  logic                tsel_high_in,
    input  logic                src5_strap_in,
    input  logic                itp_strap_in,
    input  logic                tmode_pin_in,
    input  logic                cfg_test_enter,
    input  logic                cfg_refdiv_sel,
    output logic                straps_valid,
    output logic [2:0]          fs_code_q,
    output logic [FREQ_W-1:0]   cpu_freq_10khz,
    output logic                fs_reserved,
    output logic                src5_pair_sel,
    output logic                itp_pair_sel,
    output logic                test_active,
    output logic                test_by_strap,
    output logic                out_hiz_req,
    output logic                refdiv_out
);
    logic   pg_rise;
    strap_t pins;
    strap_t held;
    tout_e  choice;
    logic   div_level;

    assign pins = '{fs: fs_pin, src5: src5_strap_in, itp: itp_strap_in, tsel: tsel_high_in};

    pg_rise_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(pwr_good_in), .rise_pulse(pg_rise)
    );

    strap_latch u_latch (
        .clk(clk), .rst(rst), .capture(pg_rise), .pins(pins),
        .valid(straps_valid), .held(held)
    );

    test_mode_ctrl u_test (
        .clk(clk), .rst(rst), .straps_ok(straps_valid), .strap_test(held.tsel),
        .sw_enter(cfg_test_enter), .tmode_pin(tmode_pin_in), .refdiv_bit(cfg_refdiv_sel),
        .active(test_active), .choice(choice)
    );

    ref_div #(.DIV_N(DIV_N)) u_div (
        .clk(clk), .rst(rst), .level(div_level)
    );

    assign fs_code_q      = held.fs;
    assign cpu_freq_10khz = straps_valid ? fs_to_freq(held.fs) : '0;
    assign fs_reserved    = straps_valid & (held.fs == 3'b111);
    assign src5_pair_sel  = held.src5;
    assign itp_pair_sel   = held.itp;
    assign test_by_strap  = held.tsel;
    assign out_hiz_req    = (choice == TOUT_HIZ);
    assign refdiv_out     = (choice == TOUT_REFDIV) & div_level;
endmodule

// File: rtl/strap_test_chk.sv
module strap_test_chk (
    input logic       clk,
    input logic       rst,
    input logic       straps_valid,
    input logic [2:0] fs_code_q,
    input logic       fs_reserved,
    input logic       src5_pair_sel,
    input logic       itp_pair_sel,
    input logic       test_active,
    input logic       test_by_strap,
    input logic       out_hiz_req,
    input logic       refdiv_out
);
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        straps_valid |=> straps_valid); // R2

    AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        straps_valid |=> ($stable(fs_code_q) && $stable(src5_pair_sel) && $stable(itp_pair_sel))); // R2

    AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (rst)
        (straps_valid && fs_code_q == 3'b111) |-> fs_reserved); // R3

    AST_STRAP_TEST_AT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        test_by_strap |-> (test_active && fs_code_q[2])); // R6

    AST_TEST_STICKY: assert property (@(posedge clk) disable iff (rst)
        test_active |=> test_active); // R9

    AST_NO_TEST_EARLY: assert property (@(posedge clk) disable iff (rst)
        !straps_valid |-> !test_active); // R9

    AST_OUTPUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !test_active |-> (!out_hiz_req && !refdiv_out)); // R10

    AST_HIZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(out_hiz_req && refdiv_out)); // R7
endmodule

bind strap_test_ctrl strap_test_chk u_chk (
    .clk(clk), .rst(rst), .straps_valid(straps_valid), .fs_code_q(fs_code_q),
    .fs_reserved(fs_reserved), .src5_pair_sel(src5_pair_sel), .itp_pair_sel(itp_pair_sel),
    .test_active(test_active), .test_by_strap(test_by_strap),
    .out_hiz_req(out_hiz_req), .refdiv_out(refdiv_out)
);

// File: tb/tb_strap_test_ctrl.sv
module tb_strap_test_ctrl;
    localparam int DIV_N = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_good_in = 1'b0;
    logic [2:0]  fs_pin = '0;
    logic        tsel_high_in = 1'b0;
    logic        src5_strap_in = 1'b0;
    logic        itp_strap_in = 1'b0;
    logic        tmode_pin_in = 1'b0;
    logic        cfg_test_enter = 1'b0;
    logic        cfg_refdiv_sel = 1'b0;
    logic        straps_valid;
    logic [2:0]  fs_code_q;
    logic [16:0] cpu_freq_10khz;
    logic        fs_reserved, src5_pair_sel, itp_pair_sel;
    logic        test_active, test_by_strap, out_hiz_req, refdiv_out;

    int checks = 0;
    int failures = 0;

    typedef struct packed {
        logic        valid;
        logic [2:0]  fs;
        logic [16:0] freq;
        logic        rsv;
        logic        src5;
        logic        itp;
        logic        tact;
        logic        tstrap;
        logic        hiz;
    } obs_t;

    obs_t  exp_q[$];
    string req_q[$];

    always #2.5 clk = ~clk;

    strap_test_ctrl #(.SYNC_STAGES(2), .DIV_N(DIV_N)) dut (
        .clk(clk), .rst(rst), .pwr_good_in(pwr_good_in), .fs_pin(fs_pin),
        .tsel_high_in(tsel_high_in), .src5_strap_in(src5_strap_in),
        .itp_strap_in(itp_strap_in), .tmode_pin_in(tmode_pin_in),
        .cfg_test_enter(cfg_test_enter), .cfg_refdiv_sel(cfg_refdiv_sel),
        .straps_valid(straps_valid), .fs_code_q(fs_code_q),
        .cpu_freq_10khz(cpu_freq_10khz), .fs_reserved(fs_reserved),
        .src5_pair_sel(src5_pair_sel), .itp_pair_sel(itp_pair_sel),
        .test_active(test_active), .test_by_strap(test_by_strap),
        .out_hiz_req(out_hiz_req), .refdiv_out(refdiv_out)
    );

    function automatic logic [16:0] freq_of(input logic [2:0] c);
        case (c)
            3'd0: return 17'd26666;
            3'd1: return 17'd13333;
            3'd2: return 17'd20000;
            3'd3: return 17'd16666;
            3'd4: return 17'd33333;
            3'd5: return 17'd10000;
            3'd6: return 17'd40000;
            default: return 17'd0;
        endcase
    endfunction

    function automatic obs_t mk(input logic v, input logic [2:0] c, input logic s5,
                                input logic it, input logic ta, input logic ts, input logic hz);
        obs_t o;
        o.valid = v;
        o.fs = v ? c : 3'd0;
        o.freq = v ? freq_of(c) : 17'd0;
        o.rsv = v && (c == 3'b111);
        o.src5 = s5; o.itp = it; o.tact = ta; o.tstrap = ts; o.hiz = hz;
        return o;
    endfunction

    function automatic obs_t observe();
        obs_t o;
        o = '{straps_valid, fs_code_q, cpu_freq_10khz, fs_reserved, src5_pair_sel,
              itp_pair_sel, test_active, test_by_strap, out_hiz_req};
        return o;
    endfunction

    // driver side: queue an expectation for the coming sample point
    task automatic expect_now(input string req, input obs_t e);
        @(negedge clk);
        exp_q.push_back(e);
        req_q.push_back(req);
        wait (exp_q.size() == 0);
    endtask

    // monitor: compare queued expectations against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                obs_t  e;
                obs_t  a;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                a = observe();
                checks++;
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", r, a, e);
                end
            end
        end
    end

    task automatic check_div(input string req, input bit active);
        logic s[2*DIV_N];
        int   ones;
        bit   ok;
        for (int i = 0; i < 2*DIV_N; i++) begin
            @(negedge clk);
            #1;
            s[i] = refdiv_out;
        end
        ones = 0;
        ok = 1'b1;
        for (int i = 0; i < DIV_N; i++) begin
            if (s[i] === 1'b1) ones++;
            if (s[i] !== s[i+DIV_N]) ok = 1'b0;
        end
        checks++;
        if (active && (!ok || ones != DIV_N/2)) begin
            failures++;
            $display("FAIL %s divided output actual_high=%0d expected_high=%0d periodic=%0d",
                     req, ones, DIV_N/2, ok);
        end else if (!active && (ones != 0 || !ok)) begin
            failures++;
            $display("FAIL %s divided output actual_high=%0d expected_high=0", req, ones);
        end
    endtask

    task automatic power_up(input logic [2:0] c, input logic ts, input logic s5, input logic it);
        @(negedge clk);
        rst = 1'b1;
        pwr_good_in = 1'b0;
        cfg_test_enter = 1'b0;
        cfg_refdiv_sel = 1'b0;
        tmode_pin_in = 1'b0;
        fs_pin = c; tsel_high_in = ts; src5_strap_in = s5; itp_strap_in = it;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pwr_good_in = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // reset state, and test entry ignored before capture
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        fs_pin = 3'b011; src5_strap_in = 1'b1; cfg_test_enter = 1'b1;
        repeat (3) @(posedge clk);
        expect_now("R1 reset state", mk(0, 0, 0, 0, 0, 0, 0));
        expect_now("R9 entry before capture", mk(0, 0, 0, 0, 0, 0, 0));
        check_div("R10 idle after reset", 1'b0);

        // frequency table, pair selects and capture latency
        for (int c = 0; c < 8; c++) begin
            logic [2:0] code;
            code = 3'(c);
            power_up(code, 1'b0, code[0], code[1]);
            expect_now("R1 not yet captured", mk(0, 0, 0, 0, 0, 0, 0));
            expect_now("R3 R4 R5 captured", mk(1, code, code[0], code[1], 0, 0, 0));
        end

        // no recapture on a later power-good pulse
        power_up(3'b101, 1'b0, 1'b1, 1'b0);
        expect_now("R1 pending", mk(0, 0, 0, 0, 0, 0, 0));
        expect_now("R1 capture", mk(1, 3'b101, 1, 0, 0, 0, 0));
        fs_pin = 3'b010; src5_strap_in = 1'b0; itp_strap_in = 1'b1; tsel_high_in = 1'b1;
        pwr_good_in = 1'b0;
        repeat (5) @(posedge clk);
        pwr_good_in = 1'b1;
        repeat (6) @(posedge clk);
        expect_now("R2 held after second rise", mk(1, 3'b101, 1, 0, 0, 0, 0));

        // test mode from the strap
        power_up(3'b001, 1'b1, 1'b0, 1'b1);
        expect_now("R6 pending", mk(0, 0, 0, 0, 0, 0, 0));
        expect_now("R6 R7 strap test hiz", mk(1, 3'b101, 0, 1, 1, 1, 1));
        check_div("R7 hiz no clock", 1'b0);
        tmode_pin_in = 1'b1;
        expect_now("R7 pin selects divided", mk(1, 3'b101, 0, 1, 1, 1, 0));
        check_div("R7 R10 divided by pin", 1'b1);
        tmode_pin_in = 1'b0; cfg_refdiv_sel = 1'b1;
        expect_now("R7 bit selects divided", mk(1, 3'b101, 0, 1, 1, 1, 0));
        check_div("R10 divided by bit", 1'b1);
        cfg_refdiv_sel = 1'b0;
        expect_now("R7 back to hiz", mk(1, 3'b101, 0, 1, 1, 1, 1));

        // test mode from the register
        power_up(3'b011, 1'b0, 1'b0, 1'b0);
        expect_now("R8 pending", mk(0, 0, 0, 0, 0, 0, 0));
        expect_now("R6 no strap test", mk(1, 3'b011, 0, 0, 0, 0, 0));
        tmode_pin_in = 1'b1;
        expect_now("R10 normal ignores pin", mk(1, 3'b011, 0, 0, 0, 0, 0));
        check_div("R10 normal no clock", 1'b0);
        cfg_test_enter = 1'b1;
        expect_now("R8 enter by register, pin ignored", mk(1, 3'b011, 0, 0, 1, 0, 1));
        check_div("R8 hiz no clock", 1'b0);
        cfg_test_enter = 1'b0;
        expect_now("R9 stays in test", mk(1, 3'b011, 0, 0, 1, 0, 1));
        cfg_refdiv_sel = 1'b1;
        expect_now("R8 bit selects divided", mk(1, 3'b011, 0, 0, 1, 0, 0));
        check_div("R8 R10 divided", 1'b1);
        @(negedge clk);
        rst = 1'b1;
        cfg_refdiv_sel = 1'b0;
        tmode_pin_in = 1'b0;
        @(posedge clk);
        expect_now("R9 power cycle clears test", mk(0, 0, 0, 0, 0, 0, 0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule